// File: doc/BRIEF.md
# I2C Receive FIFO and Acknowledge Controller

This block is the receive-side data path of an I2C controller. A byte-level bus engine hands it each received byte and tells it about bus phases: a write addressing in slave mode, a stop, the start of a master read. The block keeps the bytes in a small first-in first-out store and reports how full it is. It raises a sticky level event when the fill reaches a programmable value. It also offers a flush command that clears itself.

The block also decides how to acknowledge. In slave mode, software picks the policy for a write addressing that arrives while unread bytes remain. One policy refuses the address. The other accepts the address and then refuses and discards every data byte until the stop. In master mode, the block counts down a programmed read length, where a field value of zero means 256. It flags the final byte so the engine sends a NACK there and ends the read. An open-ended mode disables the countdown for reads of any length.

Top module: `rxq_ack_top`

## Requirements
- R1: The store holds up to DEPTH (default 8) bytes in arrival order. `fillCount` reads 0..DEPTH. `popData` shows the oldest byte. A pop on an empty store leaves `fillCount` at 0.
- R2: `threshEvt` is set one cycle after a cycle in which `fillCount >= threshLevel`. It stays set after the fill drops back below the level.
- R3: A `threshLevel` of 0 sets `threshEvt` with an empty store. A level of DEPTH sets it only once the store is full.
- R4: A `threshClr` pulse clears `threshEvt`. If the level condition still holds in that cycle, the flag stays set.
- R5: A `flushWr` pulse makes `flushBusy` read 1 for exactly one cycle. At the end of that cycle the store is empty and `flushBusy` returns to 0. A push or pop offered while `flushBusy` is 1 is discarded. With no pulse, nothing is flushed.
- R6: In slave mode with `dnrPolicy` = 1, `addrAck` is 0 during a write addressing (`addrWrMatch` = 1) while `fillCount` is nonzero, and 1 when the store is empty.
- R7: In slave mode with `dnrPolicy` = 0, a write addressing with bytes pending gives `addrAck` = 1. From the next cycle until a `stopSeen` pulse, `dataAck` reads 0 and incoming bytes are not stored.
- R8: A byte offered while the store holds DEPTH bytes is dropped and sets the sticky `overrun` flag. A pulse on `ovrClr` clears the flag.
- R9: In master mode, `mstStart` loads the read length from `xferLen`, where 0 means 256. Each received byte lowers the remaining count by one. `lastByte` reads 1, and `dataAck` 0, exactly while one byte remains.
- R10: With `irxMode` = 1, `xferLen` is ignored, `lastByte` stays 0 and master `dataAck` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| isMaster | input | 1 | 1 = master mode, 0 = slave mode |
| irxMode | input | 1 | Open-ended master read, length ignored |
| byteValid | input | 1 | A received byte is presented this cycle |
| byteData | input | 8 | Received byte |
| popReq | input | 1 | Consumer removes the oldest byte |
| popData | output | 8 | Oldest stored byte |
| fillCount | output | 4 | Number of stored bytes |
| threshLevel | input | 4 | Fill level that raises the event |
| threshEvt | output | 1 | Sticky fill-level event |
| threshClr | input | 1 | Clears the fill-level event |
| flushWr | input | 1 | Flush command pulse |
| flushBusy | output | 1 | Flush in progress, self-clearing |
| overrun | output | 1 | Sticky dropped-byte flag |
| ovrClr | input | 1 | Clears the overrun flag |
| dnrPolicy | input | 1 | Slave policy with pending bytes: 1 refuse address, 0 refuse data |
| addrWrMatch | input | 1 | Slave addressed for a write, decision needed this cycle |
| stopSeen | input | 1 | Stop condition ends the slave transfer |
| addrAck | output | 1 | ACK decision for the addressing |
| dataAck | output | 1 | ACK decision for the data byte in progress |
| mstStart | input | 1 | Load master read length |
| xferLen | input | 8 | Master read length, 0 means 256 |
| lastByte | output | 1 | Byte in progress is the final one of the read |

## Verification
`addrAck` is combinational, so the bench checks it in the same cycle, after driving `addrWrMatch` and settling. `fillCount`, `popData`, `flushBusy`, `overrun`, `dataAck` refusal and `lastByte` come from one register stage and are checked one edge after their stimulus. `threshEvt` looks at the registered count, so it lags a push by two edges: the bench adds an idle cycle before checking it. The bench drives inputs on the falling edge and reads outputs on the next falling edge, well away from the active edge.

// File: rtl/rxq_pkg.sv
`timescale 1ns/1ps
package rxq_pkg;
  // Strobes issued by the control unit to the datapath each cycle
  typedef struct packed {
    logic push;     // offer byte for storage
    logic pop;      // remove oldest byte
    logic flush;    // empty the store (wins over push/pop)
    logic loadLen;  // load master read length
    logic decLen;   // one master byte received
  } rxqStrobe_t;
endpackage

// File: rtl/rxq_datapath.sv
`timescale 1ns/1ps
module rxq_datapath
  import rxq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  parameter int LENW  = 8,
  localparam int CNTW = $clog2(DEPTH + 1),
  localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int REMW = LENW + 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  rxqStrobe_t      strb,
  input  logic [DW-1:0]   wrData,
  input  logic [CNTW-1:0] threshLevel,
  input  logic            threshClr,
  input  logic            ovrClr,
  input  logic [LENW-1:0] xferLen,
  output logic [DW-1:0]   rdData,
  output logic [CNTW-1:0] fillCount,
  output logic            threshEvt,
  output logic            overrun,
  output logic [REMW-1:0] remaining
);
  localparam logic [CNTW-1:0] FULL_CNT = CNTW'(DEPTH);
  localparam logic [PTRW-1:0] LAST_PTR = PTRW'(DEPTH - 1);
  localparam logic [REMW-1:0] MAX_LEN  = REMW'(1) << LENW;

  logic [DW-1:0]   mem [DEPTH];
  logic [PTRW-1:0] wrPtr, rdPtr;
  logic            isFull, isEmpty, doPush, doPop;

  assign isFull  = (fillCount == FULL_CNT);
  assign isEmpty = (fillCount == '0);
  assign doPush  = strb.push && !isFull && !strb.flush;
  assign doPop   = strb.pop && !isEmpty && !strb.flush;
  assign rdData  = mem[rdPtr];

  function automatic logic [PTRW-1:0] nextPtr(input logic [PTRW-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  // storage array: one register per slot
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                    mem[i] <= '0;
      else if (doPush && wrPtr == PTRW'(i))         mem[i] <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fillCount <= '0;
    end else if (strb.flush) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fillCount <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   fillCount <= fillCount + 1'b1;
        2'b01:   fillCount <= fillCount - 1'b1;
        default: fillCount <= fillCount;
      endcase
    end
  end

  // sticky level event: set wins over clear while condition holds
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) threshEvt <= 1'b0;
    else       threshEvt <= (fillCount >= threshLevel) || (threshEvt && !threshClr);
  end

  // sticky overrun on a byte offered to a full store
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                       overrun <= 1'b0;
    else if (strb.push && isFull && !strb.flush)     overrun <= 1'b1;
    else if (ovrClr)                                 overrun <= 1'b0;
  end

  // master read countdown
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                remaining <= '0;
    else if (strb.loadLen)                    remaining <= (xferLen == '0) ? MAX_LEN : REMW'(xferLen);
    else if (strb.decLen && remaining != '0)  remaining <= remaining - 1'b1;
  end
endmodule

// File: rtl/rxq_control.sv
`timescale 1ns/1ps
module rxq_control
  import rxq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int LENW  = 8,
  localparam int CNTW = $clog2(DEPTH + 1),
  localparam int REMW = LENW + 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            isMaster,
  input  logic            irxMode,
  input  logic            byteValid,
  input  logic            popReq,
  input  logic            flushWr,
  input  logic            dnrPolicy,
  input  logic            addrWrMatch,
  input  logic            stopSeen,
  input  logic            mstStart,
  input  logic [CNTW-1:0] fillCount,
  input  logic [REMW-1:0] remaining,
  output rxqStrobe_t      strb,
  output logic            flushBusy,
  output logic            addrAck,
  output logic            dataAck,
  output logic            lastByte
);
  logic rejecting;
  logic pending;

  assign pending = (fillCount != '0);

  // flush command register: set by a write of 1, cleared after one cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flushBusy <= 1'b0;
    else       flushBusy <= flushWr;
  end

  // slave data refusal until stop
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                               rejecting <= 1'b0;
    else if (stopSeen)                                       rejecting <= 1'b0;
    else if (addrWrMatch && !isMaster && !dnrPolicy && pending) rejecting <= 1'b1;
  end

  assign lastByte = isMaster && !irxMode && (remaining == REMW'(1));
  assign addrAck  = !(dnrPolicy && pending);
  assign dataAck  = isMaster ? !lastByte : !rejecting;

  always_comb begin
    strb         = '0;
    strb.flush   = flushBusy;
    strb.push    = byteValid && !flushBusy && (isMaster || !rejecting);
    strb.pop     = popReq && !flushBusy;
    strb.loadLen = mstStart && isMaster;
    strb.decLen  = byteValid && isMaster && !irxMode;
  end
endmodule

// File: rtl/rxq_ack_top.sv
`timescale 1ns/1ps
module rxq_ack_top
  import rxq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  parameter int LENW  = 8,
  localparam int CNTW = $clog2(DEPTH + 1),
  localparam int REMW = LENW + 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            isMaster,
  input  logic            irxMode,
  input  logic            byteValid,
  input  logic [DW-1:0]   byteData,
  input  logic            popReq,
  output logic [DW-1:0]   popData,
  output logic [CNTW-1:0] fillCount,
  input  logic [CNTW-1:0] threshLevel,
  output logic            threshEvt,
  input  logic            threshClr,
  input  logic            flushWr,
  output logic            flushBusy,
  output logic            overrun,
  input  logic            ovrClr,
  input  logic            dnrPolicy,
  input  logic            addrWrMatch,
  input  logic            stopSeen,
  output logic            addrAck,
  output logic            dataAck,
  input  logic            mstStart,
  input  logic [LENW-1:0] xferLen,
  output logic            lastByte
);
  rxqStrobe_t      strb;
  logic [REMW-1:0] remaining;

  rxq_control #(.DEPTH(DEPTH), .LENW(LENW)) i_ctrl (
    .clk, .rstN, .isMaster, .irxMode, .byteValid, .popReq, .flushWr,
    .dnrPolicy, .addrWrMatch, .stopSeen, .mstStart,
    .fillCount, .remaining, .strb, .flushBusy, .addrAck, .dataAck, .lastByte
  );

  rxq_datapath #(.DEPTH(DEPTH), .DW(DW), .LENW(LENW)) i_dp (
    .clk, .rstN, .strb, .wrData(byteData), .threshLevel, .threshClr, .ovrClr,
    .xferLen, .rdData(popData), .fillCount, .threshEvt, .overrun, .remaining
  );
endmodule

// File: rtl/rxq_ack_checker.sv
`timescale 1ns/1ps
module rxq_ack_checker #(
  parameter int DEPTH = 8,
  parameter int LENW  = 8,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input logic            clk,
  input logic            rstN,
  input logic            isMaster,
  input logic            irxMode,
  input logic            byteValid,
  input logic [CNTW-1:0] fillCount,
  input logic [CNTW-1:0] threshLevel,
  input logic            threshEvt,
  input logic            flushBusy,
  input logic            overrun,
  input logic            dnrPolicy,
  input logic            addrWrMatch,
  input logic            addrAck,
  input logic            dataAck,
  input logic            mstStart,
  input logic [LENW-1:0] xferLen,
  input logic            lastByte
);
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    fillCount <= CNTW'(DEPTH)); // R1

  AST_THRESH_SET: assert property (@(posedge clk) disable iff (!rstN)
    (fillCount >= threshLevel) |=> threshEvt); // R2

  AST_FLUSH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    flushBusy |=> (fillCount == '0)); // R5

  AST_ADDR_REFUSE: assert property (@(posedge clk) disable iff (!rstN)
    (addrWrMatch && !isMaster && dnrPolicy && fillCount != '0) |-> !addrAck); // R6

  AST_OVERRUN: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && !flushBusy && (isMaster || dataAck) && fillCount == CNTW'(DEPTH))
    |=> overrun); // R8

  AST_LEN_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (mstStart && isMaster && !irxMode && xferLen == LENW'(1))
    |=> (lastByte || !isMaster || irxMode)); // R9

  AST_OPEN_READ: assert property (@(posedge clk) disable iff (!rstN)
    irxMode |-> !lastByte); // R10
endmodule

bind rxq_ack_top rxq_ack_checker #(.DEPTH(DEPTH), .LENW(LENW)) i_chk (
  .clk, .rstN, .isMaster, .irxMode, .byteValid, .fillCount, .threshLevel,
  .threshEvt, .flushBusy, .overrun, .dnrPolicy, .addrWrMatch, .addrAck,
  .dataAck, .mstStart, .xferLen, .lastByte
);

// File: tb/test_rxq_ack_top.sv
`timescale 1ns/1ps
module test_rxq_ack_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       isMaster = 0, irxMode = 0, byteValid = 0, popReq = 0;
  logic [7:0] byteData = '0;
  logic [7:0] popData;
  logic [3:0] fillCount;
  logic [3:0] threshLevel = 4'd1;
  logic       threshEvt, threshClr = 0, flushWr = 0, flushBusy;
  logic       overrun, ovrClr = 0, dnrPolicy = 0, addrWrMatch = 0, stopSeen = 0;
  logic       addrAck, dataAck, mstStart = 0, lastByte;
  logic [7:0] xferLen = '0;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  rxq_ack_top i_rxq_ack_top (
    .clk, .rstN, .isMaster, .irxMode, .byteValid, .byteData, .popReq, .popData,
    .fillCount, .threshLevel, .threshEvt, .threshClr, .flushWr, .flushBusy,
    .overrun, .ovrClr, .dnrPolicy, .addrWrMatch, .stopSeen, .addrAck, .dataAck,
    .mstStart, .xferLen, .lastByte
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // inputs change on the falling edge; one active edge passes; read at next fall
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic push(input logic [7:0] d);
    byteValid = 1; byteData = d;
    step();
    byteValid = 0;
  endtask

  task automatic pop();
    popReq = 1;
    step();
    popReq = 0;
  endtask

  task automatic doFlush();
    flushWr = 1; step(); flushWr = 0; step();
  endtask

  task automatic t_reset();
    chk("R1 reset fillCount", fillCount, 0);
    chk("R2 reset threshEvt", threshEvt, 0);
    chk("R5 reset flushBusy", flushBusy, 0);
    chk("R8 reset overrun", overrun, 0);
    chk("R7 reset dataAck", dataAck, 1);
    chk("R9 reset lastByte", lastByte, 0);
  endtask

  task automatic t_fifo_order();
    threshLevel = 4'd8;
    for (int i = 0; i < 8; i++) push(8'h10 + 8'(i));
    chk("R1 full count", fillCount, 8);
    for (int i = 0; i < 8; i++) begin
      chk("R1 order", popData, 8'h10 + i);
      pop();
    end
    chk("R1 drained", fillCount, 0);
    pop();
    chk("R1 pop on empty", fillCount, 0);
    threshClr = 1; step(); threshClr = 0;
  endtask

  task automatic t_threshold();
    threshLevel = 4'd0; step();
    chk("R3 level 0 empty fires", threshEvt, 1);
    threshClr = 1; step(); threshClr = 0;
    chk("R4 clear while condition holds", threshEvt, 1);
    threshLevel = 4'd3; threshClr = 1; step(); threshClr = 0;
    chk("R4 clear", threshEvt, 0);
    push(8'h01); push(8'h02); step();
    chk("R2 below level", threshEvt, 0);
    push(8'h03);
    chk("R2 not yet (registered count)", threshEvt, 0);
    step();
    chk("R2 at level", threshEvt, 1);
    pop(); pop(); pop(); step();
    chk("R2 sticky after drain", threshEvt, 1);
    threshLevel = 4'd8; threshClr = 1; step(); threshClr = 0;
    for (int i = 0; i < 7; i++) push(8'(i));
    step();
    chk("R3 level 8 with 7 bytes", threshEvt, 0);
    push(8'h77); step();
    chk("R3 level 8 full", threshEvt, 1);
    doFlush();
    threshClr = 1; step(); threshClr = 0;
  endtask

  task automatic t_flush();
    push(8'hA1); push(8'hA2); push(8'hA3);
    step();
    chk("R5 no pulse no flush", fillCount, 3);
    flushWr = 1; step(); flushWr = 0;
    chk("R5 flushBusy set", flushBusy, 1);
    chk("R5 count before flush", fillCount, 3);
    byteValid = 1; byteData = 8'hEE; popReq = 1;
    step();
    byteValid = 0; popReq = 0;
    chk("R5 flushed, push/pop discarded", fillCount, 0);
    chk("R5 self clear", flushBusy, 0);
    step();
    chk("R5 stays clear", flushBusy, 0);
    push(8'h5A);
    chk("R5 post-flush count", fillCount, 1);
    chk("R5 post-flush data", popData, 8'h5A);
    pop();
  endtask

  task automatic t_slave();
    isMaster = 0;
    push(8'h21); push(8'h22);
    dnrPolicy = 1; addrWrMatch = 1; #1;
    chk("R6 refuse address with pending", addrAck, 0);
    step(); addrWrMatch = 0;
    chk("R6 data not refused", dataAck, 1);
    pop(); pop();
    addrWrMatch = 1; #1;
    chk("R6 accept address when empty", addrAck, 1);
    step(); addrWrMatch = 0;
    push(8'h31);
    dnrPolicy = 0; addrWrMatch = 1; #1;
    chk("R7 accept address", addrAck, 1);
    step(); addrWrMatch = 0;
    chk("R7 data refused", dataAck, 0);
    push(8'h55);
    chk("R7 byte not stored", fillCount, 1);
    chk("R7 still refused", dataAck, 0);
    stopSeen = 1; step(); stopSeen = 0;
    chk("R7 stop ends refusal", dataAck, 1);
    pop();
  endtask

  task automatic t_overrun();
    for (int i = 0; i < 8; i++) push(8'h40 + 8'(i));
    chk("R8 no overrun yet", overrun, 0);
    push(8'hEE);
    chk("R8 overrun set", overrun, 1);
    chk("R8 count stays full", fillCount, 8);
    for (int i = 0; i < 7; i++) pop();
    chk("R8 dropped byte absent", popData, 8'h47);
    pop();
    chk("R8 sticky", overrun, 1);
    ovrClr = 1; step(); ovrClr = 0;
    chk("R8 clear", overrun, 0);
  endtask

  task automatic t_master();
    isMaster = 1; irxMode = 0;
    xferLen = 8'd3; mstStart = 1; step(); mstStart = 0;
    chk("R9 len3 start", lastByte, 0);
    push(8'h01);
    chk("R9 len3 two left", lastByte, 0);
    push(8'h02);
    chk("R9 len3 last", lastByte, 1);
    chk("R9 last byte NACK", dataAck, 0);
    push(8'h03);
    chk("R9 len3 done", lastByte, 0);
    chk("R9 bytes stored", fillCount, 3);
    doFlush();
    xferLen = 8'd0; mstStart = 1; step(); mstStart = 0;
    popReq = 1; byteValid = 1;
    for (int i = 0; i < 254; i++) begin byteData = 8'(i); step(); end
    chk("R9 len256 two left", lastByte, 0);
    step();
    chk("R9 len256 last", lastByte, 1);
    step();
    popReq = 0; byteValid = 0;
    chk("R9 len256 done", lastByte, 0);
    doFlush();
  endtask

  task automatic t_irx();
    isMaster = 1; irxMode = 1;
    xferLen = 8'd1; mstStart = 1; step(); mstStart = 0;
    chk("R10 len ignored", lastByte, 0);
    push(8'h11); push(8'h12);
    chk("R10 no last", lastByte, 0);
    chk("R10 ack kept", dataAck, 1);
    doFlush();
    irxMode = 0; isMaster = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1;
    step();
    t_fifo_order();
    t_threshold();
    t_flush();
    t_slave();
    t_overrun();
    t_master();
    t_irx();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule